// File: doc/BRIEF.md
# Soft-Start Input Current Limit Sequencer

This block produces the effective input current limit code that a switching charger uses after it leaves its high-impedance (converter off) state. A register supplies the programmed full-scale limit code. The sequencer scales that code down and then brings it back up to the full value along a fixed ramp, which keeps inrush current low while the converter starts.

When high-impedance mode is released, the limit is 40% of the programmed code. It stays at that level for a long dwell (80 ms by default). After the dwell, the percentage rises once per short interval (256 µs by default) through 50, 60, 70 and 80, and then jumps straight to 100. At 100% the sequence is complete and a done flag latches. The ramp runs again only when high-impedance mode is entered again.

A microsecond prescaler, set by a cycles-per-microsecond parameter, drives both intervals. The scaled code is the programmed code times the active percentage divided by 100, with the result truncated. All outputs are registered, so they follow their inputs by one clock.

Top module: `softstart_ilim_seq`

## Requirements
- R1: While the synchronous reset is high, the outputs read limit 0, step index 0, percentage 40 and done low.
- R2: While the high-impedance flag is high, the limit output reads 0, the step index is 0, the percentage is 40 and done is low. The dwell and interval timers are cleared, so each release starts a complete new ramp.
- R3: From the first clock after release, the limit output equals floor(code × 40 / 100).
- R4: The 40% level holds for HOLD_US microsecond ticks, one tick per CLK_PER_US clocks. Step index 1 appears in the clock after tick number HOLD_US.
- R5: After the dwell, the step index rises by one every STEP_US ticks until it reaches 5, and then stays there.
- R6: Step indices 0, 1, 2, 3, 4 and 5 map to percentages 40, 50, 60, 70, 80 and 100, in that order. No index is skipped.
- R7: At step index 5 the limit equals the programmed code exactly and done is high. Done stays high until the high-impedance flag is asserted.
- R8: A change of the programmed code during the ramp appears on the limit output in the next clock, scaled by the current percentage. The ramp timing does not restart.
- R9: Asserting the high-impedance flag during the ramp or after done returns the block to the 40% step. The next release repeats the full dwell.
- R10: The scaled limit is computed in integer arithmetic and truncated toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hiz_i | input | 1 | High-impedance mode flag (converter off) |
| code_i | input | CODE_W | Programmed full-scale input current limit code |
| limit_o | output | CODE_W | Effective scaled limit code |
| step_o | output | 3 | Active ramp step index, 0 to 5 |
| pct_o | output | 7 | Active percentage of the programmed code |
| done_o | output | 1 | Soft start complete |

## Verification
The bench builds the block with CLK_PER_US=3, HOLD_US=10 and STEP_US=4. With these values a complete ramp takes 78 clocks. A short run can therefore cover the exact cycle of every step change, the prescaler phase inside each interval, a high-impedance event in the middle of the ramp and another after done. Small codes such as 7 and 1 expose the truncation at every percentage. A code of 255 checks that the product width does not overflow at full scale.

// File: rtl/ss_pkg.sv
package ss_pkg;
  localparam int STEP_W   = 3;
  localparam int PCT_W    = 7;
  localparam int LAST_IDX = 5;

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [PCT_W-1:0]  pct_t;

  // Percentage of the programmed code for each ramp position.
  function automatic pct_t step_pct(input step_t idx);
    case (idx)
      3'd0:    return 7'd40;
      3'd1:    return 7'd50;
      3'd2:    return 7'd60;
      3'd3:    return 7'd70;
      3'd4:    return 7'd80;
      default: return 7'd100;
    endcase
  endfunction
endpackage

// File: rtl/ss_us_prescaler.sv
module ss_us_prescaler #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic tick_o
);
  localparam int CNT_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  generate
    if (CLK_PER_US == 1) begin : g_direct
      assign tick_o = !hold_i && !rst;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_PER_US - 1);

      always_ff @(posedge clk) begin
        if (rst || hold_i)          cnt_q <= '0;
        else if (cnt_q == CNT_LAST) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = !hold_i && !rst && (cnt_q == CNT_LAST);

      // R4: the microsecond counter never passes its last value
      a_r4_prescale_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST);
    end
  endgenerate
endmodule

// File: rtl/ss_step_sequencer.sv
module ss_step_sequencer
  import ss_pkg::*;
#(
  parameter int HOLD_US = 80000,
  parameter int STEP_US = 256
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  hold_i,
  input  logic  tick_i,
  output step_t step_o
);
  localparam int MAX_IV = (HOLD_US > STEP_US) ? HOLD_US : STEP_US;
  localparam int IV_W   = $clog2(MAX_IV + 1);
  localparam logic [IV_W-1:0] HOLD_LAST = IV_W'(HOLD_US - 1);
  localparam logic [IV_W-1:0] STEP_LAST = IV_W'(STEP_US - 1);
  localparam step_t LAST = step_t'(LAST_IDX);

  step_t            step_q;
  logic [IV_W-1:0]  iv_q;
  logic [IV_W-1:0]  iv_last;

  assign iv_last = (step_q == '0) ? HOLD_LAST : STEP_LAST;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      step_q <= '0;
      iv_q   <= '0;
    end else if (tick_i && step_q != LAST) begin
      if (iv_q == iv_last) begin
        iv_q   <= '0;
        step_q <= step_q + 1'b1;
      end else begin
        iv_q <= iv_q + 1'b1;
      end
    end
  end

  assign step_o = step_q;

  // R6: the step either climbs by exactly one or returns to the start
  a_r6_step_order: assert property (@(posedge clk) disable iff (rst)
    (step_q != $past(step_q)) |-> (step_q == $past(step_q) + 1'b1 || step_q == '0));
  // R5: a climb happens only on a microsecond tick
  a_r5_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    (step_q != $past(step_q) && step_q != '0) |-> $past(tick_i));
  // R2: high-impedance mode forces the first step
  a_r2_hold_clears: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> step_q == '0);
  // R5: the index never passes the last step
  a_r5_step_range: assert property (@(posedge clk) disable iff (rst)
    step_q <= LAST);
endmodule

// File: rtl/ss_limit_scaler.sv
module ss_limit_scaler
  import ss_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  step_t             step_i,
  output pct_t              pct_o,
  output logic [CODE_W-1:0] scaled_o
);
  localparam int PROD_W = CODE_W + PCT_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  assign pct_o    = step_pct(step_i);
  assign prod     = PROD_W'(code_i) * PROD_W'(pct_o);
  assign quot     = prod / PROD_W'(100);
  assign scaled_o = quot[CODE_W-1:0];
endmodule

// File: rtl/softstart_ilim_seq.sv
module softstart_ilim_seq
  import ss_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int CLK_PER_US = 200,
  parameter int HOLD_US    = 80000,
  parameter int STEP_US    = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hiz_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] limit_o,
  output logic [2:0]        step_o,
  output logic [6:0]        pct_o,
  output logic              done_o
);
  logic              tick;
  step_t             step_cur;
  pct_t              pct_cur;
  logic [CODE_W-1:0] scaled;

  ss_us_prescaler #(.CLK_PER_US(CLK_PER_US)) u_pre (
    .clk(clk), .rst(rst), .hold_i(hiz_i), .tick_o(tick)
  );

  ss_step_sequencer #(.HOLD_US(HOLD_US), .STEP_US(STEP_US)) u_seq (
    .clk(clk), .rst(rst), .hold_i(hiz_i), .tick_i(tick), .step_o(step_cur)
  );

  ss_limit_scaler #(.CODE_W(CODE_W)) u_scl (
    .code_i(code_i), .step_i(step_cur), .pct_o(pct_cur), .scaled_o(scaled)
  );

  always_ff @(posedge clk) begin
    if (rst || hiz_i) begin
      limit_o <= '0;
      step_o  <= '0;
      pct_o   <= 7'd40;
      done_o  <= 1'b0;
    end else begin
      limit_o <= scaled;
      step_o  <= step_cur;
      pct_o   <= pct_cur;
      done_o  <= (step_cur == step_t'(LAST_IDX));
    end
  end

  // R2: converter off reads a zero limit
  a_r2_limit_zero: assert property (@(posedge clk) disable iff (rst)
    $past(hiz_i) |-> (limit_o == '0 && !done_o));
  // R7: done stays latched until high-impedance mode returns
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_o && !hiz_i) |=> done_o);
  // R7: the full step passes the programmed code through unchanged
  a_r7_full_exact: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (limit_o == $past(code_i) && pct_o == 7'd100));
  // R10: the scaled limit never exceeds the programmed code
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !$past(hiz_i) |-> (limit_o <= $past(code_i)));
endmodule

// File: tb/tb_softstart_ilim_seq.sv
module tb_softstart_ilim_seq;
  localparam int CODE_W = 8;
  localparam int C = 3;
  localparam int H = 10;
  localparam int S = 4;

  typedef struct packed {
    logic [CODE_W-1:0] limit;
    logic [2:0]        step;
    logic [6:0]        pct;
    logic              done;
    logic [3:0]        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hiz = 1'b1;
  logic [CODE_W-1:0] code = '0;
  logic [CODE_W-1:0] limit;
  logic [2:0] step;
  logic [6:0] pct;
  logic done;

  int checks = 0;
  int errors = 0;
  int run_cnt = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  softstart_ilim_seq #(.CODE_W(CODE_W), .CLK_PER_US(C), .HOLD_US(H), .STEP_US(S)) dut (
    .clk(clk), .rst(rst), .hiz_i(hiz), .code_i(code),
    .limit_o(limit), .step_o(step), .pct_o(pct), .done_o(done)
  );

  function automatic logic [6:0] pct_of(input int s);
    case (s)
      0: return 7'd40; 1: return 7'd50; 2: return 7'd60;
      3: return 7'd70; 4: return 7'd80; default: return 7'd100;
    endcase
  endfunction

  // Reference: derives expected outputs from the stated timing rules.
  always @(posedge clk) begin
    exp_t e;
    if (rst || hiz) begin
      e.limit = '0; e.step = '0; e.pct = 7'd40; e.done = 1'b0;
      e.tag = rst ? 4'd1 : 4'd2;            // R1 / R2
      run_cnt = 0;
    end else begin
      int ticks;
      int s;
      ticks = run_cnt / C;
      s = (ticks < H) ? 0 : 1 + (ticks - H) / S;
      if (s > 5) s = 5;
      e.step  = 3'(s);
      e.pct   = pct_of(s);
      e.limit = CODE_W'((int'(code) * int'(pct_of(s))) / 100);  // R10 truncation
      e.done  = (s == 5);
      e.tag   = (s == 0) ? 4'd4 : ((s == 5) ? 4'd7 : 4'd5);  // R4 / R7 / R5
      run_cnt++;
    end
    q.push_back(e);
  end

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1: return "R1"; 4'd2: return "R2"; 4'd4: return "R4";
      4'd5: return "R5"; default: return "R7";
    endcase
  endfunction

  // Monitor: pops and compares each expected item away from the edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (limit !== e.limit) begin
        errors++;
        $display("FAIL %s/R3/R8/R10 limit: actual %0d expected %0d", tag_name(e.tag), limit, e.limit);
      end
      if (step !== e.step || pct !== e.pct) begin
        errors++;
        $display("FAIL %s/R6 step/pct: actual %0d/%0d expected %0d/%0d", tag_name(e.tag), step, pct, e.step, e.pct);
      end
      if (done !== e.done) begin
        errors++;
        $display("FAIL %s done: actual %0b expected %0b", tag_name(e.tag), done, e.done);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 20000; wd++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    cycles(4);
    rst = 1'b0;
    // R2: high-impedance hold with a nonzero code
    code = 8'd200;
    cycles(6);
    // R3, R4, R5, R6, R7: full ramp with code 200
    hiz = 1'b0;
    cycles(100);
    // R7: done stays high, code change at 100%
    code = 8'd123;
    cycles(5);
    // R9: re-enter high impedance after done, then release again
    hiz = 1'b1;
    cycles(3);
    hiz = 1'b0;
    code = 8'd7;   // R10: truncation at every percentage
    cycles(50);
    // R8: code change in the middle of the ramp without a timing restart
    code = 8'd255;
    cycles(40);
    // R9: high impedance in the middle of the ramp
    hiz = 1'b1;
    cycles(1);
    hiz = 1'b0;
    code = 8'd1;
    cycles(45);
    code = 8'd99;
    cycles(45);
    // R1: reset in the middle of operation
    rst = 1'b1;
    cycles(3);
    rst = 1'b0;
    cycles(20);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule